// File: doc/BRIEF.md
# Display Refresh Address Generator

This block produces the sequence of video-memory word addresses needed to refresh one display, frame after frame. Software programs a small byte-wide register space. It holds a pair of output enables and, for each of the two outputs (a flat panel path and a monitor path), a colour-depth code, a horizontal width, a vertical height, a line pitch and a frame start address. While a frame is being fetched, the block walks across each raster line one 16-bit word at a time. At the end of a line it advances the line start by the pitch. It marks the last word of every line and the last word of the frame.

All settings, the enables included, are captured when a frame starts. Registers rewritten in the middle of a frame therefore only affect the next frame. Software pans vertically by writing a new start address (the line offset times the pitch in words) at any time; the picture moves at the next frame boundary and never tears. Addresses are presented on a valid/ready fetch interface, and a stalled request holds its address and flags.

Top module: `refresh_addr_gen`

## Requirements
- R1: After reset every register reads as zero and `fetch_valid`, `line_end` and `frame_end` are low.
- R2: The mode register at offset 0x00 holds the panel enable in bit 0 and the monitor enable in bit 1; while both are clear no fetch is requested.
- R3: The depth code is the low 3 bits of offset +0 within an output block. Code 2 (4 bpp) gives 2 words per 8-pixel unit, code 3 (8 bpp) gives 4 and code 5 (16 bpp) gives 8. Any other code requests no fetch.
- R4: The width byte at offset +1 holds (pixels/8)-1, so a line carries (value+1)*8 pixels and (value+1)*words-per-unit words.
- R5: The height is 10 bits, low byte at +2 and bits 9:8 in bits 1:0 of +3; a frame has value+1 lines.
- R6: The pitch is 11 bits, low byte at +4 and bits 10:8 in bits 2:0 of +5. Each line starts at the previous line start plus the pitch, and addresses wrap modulo 2^20.
- R7: The frame start is a 20-bit word address: bits 7:0 at +6, 15:8 at +7, 19:16 in bits 3:0 of +8. The first word of a frame is fetched from it.
- R8: Settings and enables written during a frame take effect only from the next frame; this is how vertical panning is applied.
- R9: The panel block is at base 0x10 and the monitor block at 0x20. With the panel enable set, the panel block is used even if the monitor enable is also set.
- R10: While `fetch_valid` is high and `fetch_ready` is low, the address, `line_end` and `frame_end` hold.
- R11: `line_end` marks the last word of each line and `frame_end` the last word of the frame. After the frame's last handshake, `fetch_valid` is low for one cycle before the next frame begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 8 | Register byte offset |
| reg_wr_data | input | 8 | Register write data |
| fetch_ready | input | 1 | Memory side accepts the current address |
| fetch_valid | output | 1 | A word address is being requested |
| fetch_addr | output | 20 | Word address to fetch |
| line_end | output | 1 | Current word is the last of its line |
| frame_end | output | 1 | Current word is the last of the frame |

## Verification
The generator is driven through each legal depth code with a few widths, so that the word count per frame separates the three scale factors from each other and from an invalid code that must stay silent. A height above 255 lines exercises the split height field. A start near the top of the address space with a large pitch checks the carry into the next line and the wrap. Start and depth rewrites in mid-frame, random back-pressure on the fetch side, and switching between panel-only, both and monitor-only enables separate frame-boundary capture, stall holding and output priority.

// File: rtl/apg_pkg.sv
package apg_pkg;
    parameter int ADDR_W   = 20;
    parameter int PITCH_W  = 11;
    parameter int HEIGHT_W = 10;
    parameter int HUNIT_W  = 8;
    parameter int DEPTH_W  = 3;
    parameter int REG_AW   = 8;
    parameter int NUM_OUT  = 2;
    // a line can hold 256 units of 8 words
    parameter int COL_W    = HUNIT_W + 4;

    parameter logic [REG_AW-1:0] OFS_MODE  = 8'h00;
    parameter logic [3:0]        OUT_BASE0 = 4'h1;
    parameter logic [3:0]        F_DEPTH   = 4'h0;
    parameter logic [3:0]        F_HUNITS  = 4'h1;
    parameter logic [3:0]        F_VLO     = 4'h2;
    parameter logic [3:0]        F_VHI     = 4'h3;
    parameter logic [3:0]        F_PLO     = 4'h4;
    parameter logic [3:0]        F_PHI     = 4'h5;
    parameter logic [3:0]        F_S0      = 4'h6;
    parameter logic [3:0]        F_S1      = 4'h7;
    parameter logic [3:0]        F_S2      = 4'h8;

    parameter logic [DEPTH_W-1:0] DEPTH_4  = 3'd2;
    parameter logic [DEPTH_W-1:0] DEPTH_8  = 3'd3;
    parameter logic [DEPTH_W-1:0] DEPTH_16 = 3'd5;

    typedef struct packed {
        logic [DEPTH_W-1:0]  depth;
        logic [HUNIT_W-1:0]  hunits;
        logic [HEIGHT_W-1:0] vlines;
        logic [PITCH_W-1:0]  pitch;
        logic [ADDR_W-1:0]   start;
    } out_cfg_t;
endpackage

// File: rtl/apg_regs.sv
module apg_regs
    import apg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic [1:0]        mode,
    output out_cfg_t [NUM_OUT-1:0] cfg
);
    typedef struct packed {
        logic [1:0]              mode;
        out_cfg_t [NUM_OUT-1:0]  cfg;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (wr_addr == OFS_MODE) r_d.mode = wr_data[1:0];
            for (int o = 0; o < NUM_OUT; o++) begin
                if (wr_addr[7:4] == OUT_BASE0 + 4'(o)) begin
                    case (wr_addr[3:0])
                        F_DEPTH:  r_d.cfg[o].depth        = wr_data[DEPTH_W-1:0];
                        F_HUNITS: r_d.cfg[o].hunits       = wr_data;
                        F_VLO:    r_d.cfg[o].vlines[7:0]  = wr_data;
                        F_VHI:    r_d.cfg[o].vlines[9:8]  = wr_data[1:0];
                        F_PLO:    r_d.cfg[o].pitch[7:0]   = wr_data;
                        F_PHI:    r_d.cfg[o].pitch[10:8]  = wr_data[2:0];
                        F_S0:     r_d.cfg[o].start[7:0]   = wr_data;
                        F_S1:     r_d.cfg[o].start[15:8]  = wr_data;
                        F_S2:     r_d.cfg[o].start[19:16] = wr_data[3:0];
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mode = r_q.mode;
    assign cfg  = r_q.cfg;

    p_mode_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == OFS_MODE) |=> (mode == $past(wr_data[1:0])));
endmodule

// File: rtl/apg_select.sv
module apg_select
    import apg_pkg::*;
(
    input  logic [1:0]             mode,
    input  out_cfg_t [NUM_OUT-1:0] cfg,
    output logic                   active,
    output out_cfg_t               sel_cfg,
    output logic [COL_W-1:0]       words_per_line
);
    logic [1:0]       shift;
    logic             depth_ok;
    logic [COL_W-1:0] units;

    always_comb begin
        // panel path wins when its enable is set
        sel_cfg = mode[0] ? cfg[0] : cfg[1];
        depth_ok = 1'b1;
        case (sel_cfg.depth)
            DEPTH_4:  shift = 2'd1;
            DEPTH_8:  shift = 2'd2;
            DEPTH_16: shift = 2'd3;
            default: begin
                shift    = 2'd0;
                depth_ok = 1'b0;
            end
        endcase
        units          = COL_W'(sel_cfg.hunits) + COL_W'(1);
        words_per_line = units << shift;
        active         = (mode != 2'b00) && depth_ok;
    end
endmodule

// File: rtl/apg_seq.sv
module apg_seq
    import apg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  out_cfg_t          sel_cfg,
    input  logic [COL_W-1:0]  words_per_line,
    input  logic              fetch_ready,
    output logic              fetch_valid,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              line_end,
    output logic              frame_end
);
    typedef struct packed {
        logic                run;
        logic [ADDR_W-1:0]   line;
        logic [COL_W-1:0]    col;
        logic [COL_W-1:0]    col_last;
        logic [HEIGHT_W-1:0] row;
        logic [HEIGHT_W-1:0] row_last;
        logic [PITCH_W-1:0]  pitch;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!s_q.run) begin
            if (active) begin
                s_d.run      = 1'b1;
                s_d.line     = sel_cfg.start;
                s_d.col      = '0;
                s_d.row      = '0;
                s_d.col_last = words_per_line - COL_W'(1);
                s_d.row_last = sel_cfg.vlines;
                s_d.pitch    = sel_cfg.pitch;
            end
        end else if (fetch_ready) begin
            if (s_q.col == s_q.col_last) begin
                s_d.col = '0;
                if (s_q.row == s_q.row_last) begin
                    s_d.run = 1'b0;
                end else begin
                    s_d.row  = s_q.row + HEIGHT_W'(1);
                    s_d.line = s_q.line + ADDR_W'(s_q.pitch);
                end
            end else begin
                s_d.col = s_q.col + COL_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fetch_valid = s_q.run;
    assign fetch_addr  = s_q.line + ADDR_W'(s_q.col);
    assign line_end    = s_q.run && (s_q.col == s_q.col_last);
    assign frame_end   = line_end && (s_q.row == s_q.row_last);

    p_start_needs_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fetch_valid) |-> $past(active));
    p_hold_on_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && !fetch_ready) |=>
            (fetch_valid && $stable(fetch_addr) && $stable(line_end) && $stable(frame_end)));
    p_eof_on_eol_r11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> line_end);
    p_gap_after_eof_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && fetch_ready && frame_end) |=> !fetch_valid);
    p_pitch_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && $past(fetch_valid)) |-> $stable(s_q.pitch));
    p_line_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && fetch_ready && line_end && !frame_end) |=>
            (fetch_addr == $past(s_q.line) + ADDR_W'($past(s_q.pitch))));
endmodule

// File: rtl/refresh_addr_gen.sv
module refresh_addr_gen
    import apg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_wr_addr,
    input  logic [7:0]        reg_wr_data,
    input  logic              fetch_ready,
    output logic              fetch_valid,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              line_end,
    output logic              frame_end
);
    logic [1:0]             mode;
    out_cfg_t [NUM_OUT-1:0] cfg;
    logic                   active;
    out_cfg_t               sel_cfg;
    logic [COL_W-1:0]       words_per_line;

    apg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_addr (reg_wr_addr),
        .wr_data (reg_wr_data),
        .mode    (mode),
        .cfg     (cfg)
    );

    apg_select u_sel (
        .mode           (mode),
        .cfg            (cfg),
        .active         (active),
        .sel_cfg        (sel_cfg),
        .words_per_line (words_per_line)
    );

    apg_seq u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .active         (active),
        .sel_cfg        (sel_cfg),
        .words_per_line (words_per_line),
        .fetch_ready    (fetch_ready),
        .fetch_valid    (fetch_valid),
        .fetch_addr     (fetch_addr),
        .line_end       (line_end),
        .frame_end      (frame_end)
    );
endmodule

// File: tb/refresh_addr_gen_tb_top.sv
module refresh_addr_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_wr_addr = '0;
    logic [7:0]  reg_wr_data = '0;
    logic        fetch_ready = 1'b1;
    logic        fetch_valid;
    logic [19:0] fetch_addr;
    logic        line_end;
    logic        frame_end;

    always #4 clk = ~clk;

    refresh_addr_gen dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_addr (reg_wr_addr),
        .reg_wr_data (reg_wr_data),
        .fetch_ready (fetch_ready),
        .fetch_valid (fetch_valid),
        .fetch_addr  (fetch_addr),
        .line_end    (line_end),
        .frame_end   (frame_end)
    );

    int    errors = 0;
    int    checks = 0;
    string cur_req = "R1";
    bit    stall_mode = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    // reference model state
    int m_mode = 0;
    int m_cfg [2][9];
    bit m_run = 0;
    int m_line = 0, m_col = 0, m_row = 0, m_wpl = 0, m_rows = 0, m_pitch = 0;

    // observation counters
    int eof_cnt = 0;
    int words_in_frame = 0;
    int last_frame_words = 0;
    int valid_cycles = 0;

    function automatic int mult_of(int d);
        case (d)
            2: return 2;
            3: return 4;
            5: return 8;
            default: return 0;
        endcase
    endfunction

    task automatic check(string req, bit ok, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // model update with the values present before the edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_mode = 0;
            for (int o = 0; o < 2; o++) for (int f = 0; f < 9; f++) m_cfg[o][f] = 0;
        end else begin
            if (fetch_valid) valid_cycles++;
            if (fetch_valid && fetch_ready) begin
                words_in_frame++;
                if (frame_end) begin
                    eof_cnt++;
                    last_frame_words = words_in_frame;
                    words_in_frame = 0;
                end
            end
            if (!m_run) begin
                int s, d;
                s = (m_mode & 1) ? 0 : 1;
                d = m_cfg[s][0] & 7;
                if ((m_mode & 3) != 0 && mult_of(d) != 0) begin
                    m_run   = 1;
                    m_col   = 0;
                    m_row   = 0;
                    m_line  = m_cfg[s][6] | (m_cfg[s][7] << 8) | ((m_cfg[s][8] & 15) << 16);
                    m_wpl   = (m_cfg[s][1] + 1) * mult_of(d);
                    m_rows  = (m_cfg[s][2] | ((m_cfg[s][3] & 3) << 8)) + 1;
                    m_pitch = m_cfg[s][4] | ((m_cfg[s][5] & 7) << 8);
                end
            end else if (fetch_ready) begin
                if (m_col == m_wpl - 1) begin
                    m_col = 0;
                    if (m_row == m_rows - 1) m_run = 0;
                    else begin
                        m_row++;
                        m_line = (m_line + m_pitch) & 32'hFFFFF;
                    end
                end else m_col++;
            end
            if (reg_wr_en) begin
                if (reg_wr_addr == 8'h00) m_mode = reg_wr_data & 3;
                else if (reg_wr_addr[3:0] < 4'd9 &&
                         (reg_wr_addr[7:4] == 4'h1 || reg_wr_addr[7:4] == 4'h2))
                    m_cfg[reg_wr_addr[7:4] - 1][reg_wr_addr[3:0]] = reg_wr_data;
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit e_eol, e_eof;
            int e_addr;
            e_eol  = m_run && (m_col == m_wpl - 1);
            e_eof  = e_eol && (m_row == m_rows - 1);
            e_addr = (m_line + m_col) & 32'hFFFFF;
            check({cur_req, "/R11 valid"}, fetch_valid == m_run, fetch_valid, m_run);
            if (m_run) begin
                check({cur_req, " addr"}, fetch_addr == e_addr[19:0], fetch_addr, e_addr);
                check({cur_req, "/R11 flags"}, {line_end, frame_end} == {e_eol, e_eof},
                      {line_end, frame_end}, {e_eol, e_eof});
            end
        end
    end

    // fetch-side back-pressure
    always @(negedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        fetch_ready = stall_mode ? lfsr[0] : 1'b1;
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); #1;
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(negedge clk); #1;
        reg_wr_en = 1'b0;
    endtask

    task automatic cfg_out(input logic [7:0] base, input int depth, input int hu,
                           input int vl, input int pitch, input int start);
        wr(base + 8'h0, 8'(depth));
        wr(base + 8'h1, 8'(hu));
        wr(base + 8'h2, 8'(vl));
        wr(base + 8'h3, 8'(vl >> 8));
        wr(base + 8'h4, 8'(pitch));
        wr(base + 8'h5, 8'(pitch >> 8));
        wr(base + 8'h6, 8'(start));
        wr(base + 8'h7, 8'(start >> 8));
        wr(base + 8'h8, 8'(start >> 16));
    endtask

    task automatic wait_eofs(input int n);
        int target;
        target = eof_cnt + n;
        while (eof_cnt < target) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_window(input string req, input int n);
        valid_cycles = 0;
        repeat (n) @(negedge clk);
        check(req, valid_cycles == 0, valid_cycles, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {fetch_valid, line_end, frame_end} == 3'b000,
              {fetch_valid, line_end, frame_end}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", fetch_valid == 1'b0, fetch_valid, 0);

        // R2: configured but both enables clear
        cur_req = "R2";
        cfg_out(8'h10, 3, 1, 2, 20, 'h100);
        idle_window("R2", 20);

        // R4: 8 bpp, 16 px -> 8 words, 3 lines
        cur_req = "R4";
        wr(8'h00, 8'h01);
        wait_eofs(2);
        check("R4", last_frame_words == 24, last_frame_words, 24);

        // R3: depth change mid-frame, then 4 bpp and 16 bpp
        cur_req = "R3";
        wr(8'h10, 8'd2);
        wait_eofs(2);
        check("R3 4bpp", last_frame_words == 12, last_frame_words, 12);
        wr(8'h10, 8'd5);
        wait_eofs(2);
        check("R3 16bpp", last_frame_words == 48, last_frame_words, 48);
        wr(8'h10, 8'd4);
        wait_eofs(1);
        idle_window("R3 bad code", 30);

        // R5: 258 lines via the split height field
        cur_req = "R5";
        cfg_out(8'h10, 2, 0, 'h101, 4, 'h2000);
        wait_eofs(2);
        check("R5", last_frame_words == 516, last_frame_words, 516);

        // R6/R7: start near the top, wide pitch, wrap
        cur_req = "R6";
        cfg_out(8'h10, 5, 0, 3, 'h7FF, 'hFFFF0);
        wait_eofs(2);
        check("R7", last_frame_words == 32, last_frame_words, 32);

        // R8: pan by rewriting start mid-frame
        cur_req = "R8";
        cfg_out(8'h10, 3, 3, 7, 32, 'h0);
        wait_eofs(1);
        repeat (10) @(negedge clk);
        wr(8'h16, 8'h40);
        wr(8'h17, 8'h01);
        wait_eofs(2);
        check("R8", last_frame_words == 128, last_frame_words, 128);

        // R10: random back-pressure
        cur_req = "R10";
        stall_mode = 1'b1;
        wait_eofs(3);
        check("R10", last_frame_words == 128, last_frame_words, 128);
        stall_mode = 1'b0;

        // R9: panel has priority, monitor used alone
        cur_req = "R9";
        cfg_out(8'h20, 3, 0, 1, 8, 'h5000);
        wr(8'h00, 8'h03);
        wait_eofs(2);
        check("R9 both", last_frame_words == 128, last_frame_words, 128);
        wr(8'h00, 8'h02);
        wait_eofs(2);
        check("R9 monitor", last_frame_words == 8, last_frame_words, 8);

        // R2: disable takes effect at the frame boundary
        cur_req = "R11";
        wr(8'h00, 8'h00);
        wait_eofs(1);
        idle_window("R2 off", 20);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule